// File: doc/BRIEF.md
# DMA-Fed Video Pixel Serializer

This block turns bytes that arrive over a direct-memory-access transfer into a one-bit monochrome video stream. The processor drives its state-code pins to a "DMA out" value during each DMA cycle. While that value is present, a rising edge on the processor's second timing strobe copies the data bus into an 8-bit shift register. The register then sends the byte to the video output, most significant bit first. It moves one bit on each high-to-low transition of the pixel clock input, and a zero enters behind the data.

A display line is eight such bytes, or 64 pixels. If the next byte is loaded on the same clock as the eighth shift, the bits follow each other with no gap. Between DMA cycles the register empties to zeros and the screen stays black. A display-enable input blanks the output without stopping the shifting.

All inputs are sampled on the system clock `clk`. The pixel clock and the strobe are edge-detected against their values from the previous cycle, so both are plain synchronous signals.

Top module: `pixel_serializer`

## Requirements
- R1: While `rst` is high, and afterwards until the first load, `video` is 0 and the shift register holds all zeros.
- R2: A load happens in the cycle where `strobeB` is 1, it was 0 in the previous cycle, and `stateCode` equals 2'b01 (bit 1 low, bit 0 high). After that clock edge, `video` shows bit 7 of `dataBus`.
- R3: A rising edge of `strobeB` loads nothing while `stateCode` is 2'b00, 2'b10 or 2'b11.
- R4: A shift happens in each cycle where `pixClk` is 0 and was 1 in the previous cycle. Bits leave the register most significant first, so `video` shows bits 7, 6 … 0 in turn.
- R5: Each shift puts a 0 into bit 0. After eight shifts with no load, `video` is 0, and it stays 0 for every later shift.
- R6: If a load and a shift fall in the same cycle, the load wins. The new byte's bit 7 appears, and its bit 6 appears at the next pixel-clock fall.
- R7: When eight bytes are loaded back to back, each on the same cycle as the previous byte's eighth shift, `video` carries all 64 bits in order with no gap or repeat.
- R8: While `dispEn` is 0, `video` is 0. The register still loads and shifts, so raising `dispEn` shows the bit that has reached position 7 at that time.
- R9: If `strobeB` stays high, it loads only once. A new byte needs the strobe to return low first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pixClk | input | 1 | Pixel clock level; a 1-to-0 change triggers one shift |
| strobeB | input | 1 | Second timing strobe; a 0-to-1 change triggers a qualified load |
| stateCode | input | 2 | Processor state code; 2'b01 marks a DMA-out cycle |
| dataBus | input | 8 | Byte fetched by DMA |
| dispEn | input | 1 | Display enable; 0 blanks the video |
| video | output | 1 | Serial pixel output |

## Verification
Every one of the 256 byte values is loaded and shifted out. Each bit is compared against the byte by arithmetic, which catches a wrong bit order, a dropped or duplicated bit, and bad zero fill. A 64-bit line of eight back-to-back bytes shows whether the load-over-shift priority removes the gap between bytes. Load attempts under all four state codes, a strobe held high, and enable toggled in the middle of a byte separate correct qualification, edge detection and blanking from the level-sensitive or unqualified forms of the same logic.

// File: rtl/pixel_serializer_pkg.sv
package pixel_serializer_pkg;
  localparam int BYTE_W = 8;
  localparam logic [1:0] DMA_OUT_CODE = 2'b01;

  typedef struct packed {
    logic load;
    logic shift;
  } serStrobes_t;
endpackage

// File: rtl/pixel_ser_ctl.sv
module pixel_ser_ctl
  import pixel_serializer_pkg::*;
#(
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pixClk,
  input  logic              strobeB,
  input  logic [CODE_W-1:0] stateCode,
  output serStrobes_t       strb
);
  logic pixPrev;
  logic strobePrev;

  always_ff @(posedge clk) begin
    if (rst) begin
      pixPrev    <= 1'b0;
      strobePrev <= 1'b0;
    end else begin
      pixPrev    <= pixClk;
      strobePrev <= strobeB;
    end
  end

  always_comb begin
    strb.load  = strobeB && !strobePrev && (stateCode == CODE_W'(DMA_OUT_CODE));
    strb.shift = pixPrev && !pixClk;
  end

  // R9
  single_load_chk: assert property (@(posedge clk) disable iff (rst)
    strb.load |=> !strb.load);

  // R4
  single_shift_chk: assert property (@(posedge clk) disable iff (rst)
    strb.shift |=> !strb.shift);
endmodule

// File: rtl/pixel_ser_dp.sv
module pixel_ser_dp
  import pixel_serializer_pkg::*;
#(
  parameter int WIDTH = BYTE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  serStrobes_t      strb,
  input  logic [WIDTH-1:0] busIn,
  output logic             msbOut
);
  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] shReg;

  always_ff @(posedge clk) begin
    if (rst)
      shReg <= '0;
    else if (strb.load)
      shReg <= busIn;
    else if (strb.shift)
      shReg <= {shReg[TOP-1:0], 1'b0};
  end

  assign msbOut = shReg[TOP];

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (shReg == '0));

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    strb.load |=> (shReg == $past(busIn)));

  // R5
  zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.shift && !strb.load) |=> (shReg[0] == 1'b0 && shReg[TOP:1] == $past(shReg[TOP-1:0])));
endmodule

// File: rtl/pixel_serializer.sv
module pixel_serializer
  import pixel_serializer_pkg::*;
#(
  parameter int WIDTH  = BYTE_W,
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pixClk,
  input  logic              strobeB,
  input  logic [CODE_W-1:0] stateCode,
  input  logic [WIDTH-1:0]  dataBus,
  input  logic              dispEn,
  output logic              video
);
  serStrobes_t strb;
  logic        msbOut;

  pixel_ser_ctl #(.CODE_W(CODE_W)) u_ctl (
    .clk(clk), .rst(rst), .pixClk(pixClk), .strobeB(strobeB),
    .stateCode(stateCode), .strb(strb)
  );

  pixel_ser_dp #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .busIn(dataBus), .msbOut(msbOut)
  );

  assign video = msbOut && dispEn;

  // R8
  blank_chk: assert property (@(posedge clk) disable iff (rst)
    !dispEn |-> !video);
endmodule

// File: tb/sim_pixel_serializer.sv
module sim_pixel_serializer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pixClk = 1'b0;
  logic strobeB = 1'b0;
  logic [1:0] stateCode = 2'b00;
  logic [7:0] dataBus = 8'h00;
  logic dispEn = 1'b1;
  logic video;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pixel_serializer u0 (
    .clk(clk), .rst(rst), .pixClk(pixClk), .strobeB(strobeB),
    .stateCode(stateCode), .dataBus(dataBus), .dispEn(dispEn), .video(video)
  );

  task automatic check(input logic act, input logic exp, input string req);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: video=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic pc, input logic sb);
    pixClk = pc;
    strobeB = sb;
    @(negedge clk);
  endtask

  task automatic loadByte(input logic [7:0] b);
    dataBus = b;
    stateCode = 2'b01;
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
  endtask

  task automatic fall();
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  initial begin
    @(negedge clk);
    check(video, 1'b0, "R1 in reset");
    loadByte(8'hFF);
    check(video, 1'b0, "R1 load ignored in reset");
    rst = 1'b0;
    @(negedge clk);
    check(video, 1'b0, "R1 after reset");
    fall();
    check(video, 1'b0, "R1 register cleared");

    // R2 R4 R5: all byte values, MSB first with zero fill
    for (int v = 0; v < 256; v++) begin
      loadByte(v[7:0]);
      check(video, v[7], "R2 msb after load");
      for (int k = 6; k >= 0; k--) begin
        fall();
        check(video, v[k], "R4 bit order");
      end
      fall();
      check(video, 1'b0, "R5 drained after 8");
      fall();
      check(video, 1'b0, "R5 stays dark");
    end

    // R3: wrong state codes do not load
    for (int c = 0; c < 4; c++) begin
      if (c != 1) begin
        stateCode = c[1:0];
        dataBus = 8'hFF;
        step(1'b0, 1'b1);
        step(1'b0, 1'b0);
        check(video, 1'b0, "R3 no load msb");
        fall();
        check(video, 1'b0, "R3 no load bit6");
      end
    end

    // R9: strobe held high loads once
    dataBus = 8'h80;
    stateCode = 2'b01;
    step(1'b0, 1'b1);
    check(video, 1'b1, "R9 first load");
    dataBus = 8'hFF;
    step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    check(video, 1'b0, "R9 no reload while high");
    step(1'b0, 1'b0);
    for (int k = 0; k < 8; k++) fall();

    // R7 R6: eight bytes back to back, 64 bits
    begin
      logic [63:0] line;
      line = 64'hC3A5_0F96_7E18_F001;
      loadByte(line[63:56]);
      for (int i = 63; i >= 0; i--) begin
        check(video, line[i], (i % 8 == 7) ? "R6 merged load msb" : "R7 line bit");
        if (i % 8 == 0 && i != 0) begin
          step(1'b1, 1'b0);
          dataBus = line[i-1 -: 8];
          step(1'b0, 1'b1);
          step(1'b0, 1'b0);
        end else if (i != 0) begin
          fall();
        end
      end
      fall();
      check(video, 1'b0, "R7 line drained");
    end

    // R8: blanking while shifting continues
    dispEn = 1'b0;
    loadByte(8'hA5);
    check(video, 1'b0, "R8 blanked after load");
    fall();
    fall();
    check(video, 1'b0, "R8 blanked while shifting");
    dispEn = 1'b1;
    #1;
    check(video, 1'b1, "R8 bit5 visible");
    fall();
    check(video, 1'b0, "R8 bit4 visible");

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog: run hung, actual=timeout expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule